// File: doc/BRIEF.md
# Write Strobe Narrowing Shim

This block sits between a write-issuing manager and a memory-mapped subordinate that cannot handle partial byte enables. It forwards the write-address, write-data and write-response channels of a single-beat write path. When the byte-enable pattern of the current data beat is a single byte, or an aligned halfword that is narrower than the bus, the shim rewrites the outgoing transfer size and the low address bits. The subordinate then sees an ordinary narrow access and can ignore the strobes.

The rewrite is purely combinational and follows the strobe of the current write-data beat, so the address and data of one transaction are expected to be presented together. Every other strobe pattern passes the incoming address and size through unchanged. Examples are all-zero, all-ones, misaligned pairs, three-byte runs and gapped patterns. Handshakes cross the shim with no added latency. Multi-beat bursts and read channels are outside its scope.

Top module: `wstrb_narrow_shim`

## Requirements
- R1: With the default 32-bit data bus, a strobe of exactly one set bit (0x1, 0x2, 0x4, 0x8) drives the outgoing size to 0 (one byte). Address bits [1:0] become the index of that set bit (0, 1, 2, 3).
- R2: A strobe of 0x3 drives the outgoing size to 1 (two bytes) with address bits [1:0] = 0. A strobe of 0xC drives size 1 with address bits [1:0] = 2.
- R3: A strobe of 0x0 leaves the outgoing address and size equal to the incoming ones (for example size 2 at 0x5550 stays size 2 at 0x5550).
- R4: A strobe of 0xF, and every pattern not covered by R1 or R2 (misaligned pairs such as 0x6, three-byte runs, gapped patterns such as 0x5), leaves the outgoing address and size equal to the incoming ones.
- R5: Outgoing address bits above bit 1 always equal the incoming address bits. Only bits [1:0] are ever replaced.
- R6: The outgoing address-valid equals the incoming address-valid, and the incoming address-ready equals the outgoing address-ready, in the same cycle.
- R7: The outgoing data-valid equals the incoming data-valid, and the incoming data-ready equals the outgoing data-ready, in the same cycle. Both are low while the ports are idle after reset.
- R8: The outgoing write data, strobe and last flag equal the incoming beat's values.
- R9: The response valid, ready and 2-bit response code cross the shim unchanged in their respective directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_awvalid | input | 1 | Address valid from the manager |
| up_awready | output | 1 | Address ready to the manager |
| up_awaddr | input | ADDR_W | Write address from the manager |
| up_awsize | input | 3 | Transfer size code from the manager (log2 bytes) |
| up_wvalid | input | 1 | Data valid from the manager |
| up_wready | output | 1 | Data ready to the manager |
| up_wdata | input | DATA_W | Write data from the manager |
| up_wstrb | input | DATA_W/8 | Byte enables from the manager |
| up_wlast | input | 1 | Last-beat flag from the manager |
| up_bvalid | output | 1 | Response valid to the manager |
| up_bready | input | 1 | Response ready from the manager |
| up_bresp | output | 2 | Response code to the manager |
| dn_awvalid | output | 1 | Address valid to the subordinate |
| dn_awready | input | 1 | Address ready from the subordinate |
| dn_awaddr | output | ADDR_W | Possibly narrowed address to the subordinate |
| dn_awsize | output | 3 | Possibly narrowed size code to the subordinate |
| dn_wvalid | output | 1 | Data valid to the subordinate |
| dn_wready | input | 1 | Data ready from the subordinate |
| dn_wdata | output | DATA_W | Write data to the subordinate |
| dn_wstrb | output | DATA_W/8 | Byte enables to the subordinate |
| dn_wlast | output | 1 | Last-beat flag to the subordinate |
| dn_bvalid | input | 1 | Response valid from the subordinate |
| dn_bready | output | 1 | Response ready to the subordinate |
| dn_bresp | input | 2 | Response code from the subordinate |

## Verification
The assertions check the structural invariants at every settled input change. Handshake and payload forwarding, preservation of the upper address bits, and at most one matching narrowing slot are all checked this way. So is the rule that any changed size or offset describes a lane run whose byte count and start agree with the strobe. Only the bench's scenarios can confirm that each specific strobe code selects the expected size and offset, and that the near-miss patterns (misaligned pairs, three-byte runs, gaps, all-ones) are left alone. The bench sweeps all sixteen strobe codes across several base addresses and sizes and every combination of the six handshake bits.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  localparam int SIZE_W = 3;
  localparam int RESP_W = 2;
  typedef logic [SIZE_W-1:0] axsize_t;
endpackage

// File: rtl/nrw_strb_decode.sv
// Matches the byte-enable vector against every aligned, power-of-two lane
// run narrower than the bus and reports the offset and size of the match.
module nrw_strb_decode
  import nrw_pkg::*;
#(
  parameter  int STRB_W = 4,
  localparam int LSB_W  = $clog2(STRB_W),
  localparam int NSLOT  = 2 * STRB_W - 2
) (
  input  logic [STRB_W-1:0] strb,
  output logic [NSLOT-1:0]  slot_hit,
  output logic              narrow,
  output logic [LSB_W-1:0]  offset,
  output axsize_t           nsize
);
  logic [LSB_W-1:0] slot_off [NSLOT];
  axsize_t          slot_sz  [NSLOT];

  for (genvar s = 0; s < LSB_W; s++) begin : g_size
    localparam int LANES = 1 << s;
    localparam int SLOTS = STRB_W >> s;
    localparam int BASE  = 2 * STRB_W - 2 * SLOTS;
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      localparam logic [STRB_W-1:0] MASK =
        {{(STRB_W-LANES){1'b0}}, {LANES{1'b1}}} << (k * LANES);
      assign slot_hit[BASE+k] = (strb == MASK);
      assign slot_off[BASE+k] = LSB_W'(k * LANES);
      assign slot_sz[BASE+k]  = axsize_t'(s);
    end
  end

  always_comb begin
    narrow = |slot_hit;
    offset = '0;
    nsize  = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_hit[i]) begin
        offset = slot_off[i];
        nsize  = slot_sz[i];
      end
    end
  end
endmodule

// File: rtl/nrw_aw_rewrite.sv
// Substitutes the low address bits and the size code when a narrowing
// slot matched; otherwise the address phase passes unchanged.
module nrw_aw_rewrite
  import nrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LSB_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  axsize_t           size_in,
  input  logic              narrow,
  input  logic [LSB_W-1:0]  offset,
  input  axsize_t           nsize,
  output logic [ADDR_W-1:0] addr_out,
  output axsize_t           size_out
);
  always_comb begin
    addr_out = addr_in;
    size_out = size_in;
    if (narrow) begin
      addr_out[LSB_W-1:0] = offset;
      size_out            = nsize;
    end
  end
endmodule

// File: rtl/nrw_chan_pass.sv
// Zero-latency forwarding of handshakes, data beat and write response.
module nrw_chan_pass
  import nrw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              up_awvalid,
  output logic              up_awready,
  output logic              dn_awvalid,
  input  logic              dn_awready,
  input  logic              up_wvalid,
  output logic              up_wready,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [STRB_W-1:0] up_wstrb,
  input  logic              up_wlast,
  output logic              dn_wvalid,
  input  logic              dn_wready,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [STRB_W-1:0] dn_wstrb,
  output logic              dn_wlast,
  output logic              up_bvalid,
  input  logic              up_bready,
  output logic [RESP_W-1:0] up_bresp,
  input  logic              dn_bvalid,
  output logic              dn_bready,
  input  logic [RESP_W-1:0] dn_bresp
);
  assign dn_awvalid = up_awvalid;
  assign up_awready = dn_awready;
  assign dn_wvalid  = up_wvalid;
  assign up_wready  = dn_wready;
  assign dn_wdata   = up_wdata;
  assign dn_wstrb   = up_wstrb;
  assign dn_wlast   = up_wlast;
  assign up_bvalid  = dn_bvalid;
  assign dn_bready  = up_bready;
  assign up_bresp   = dn_bresp;
endmodule

// File: rtl/wstrb_narrow_shim.sv
module wstrb_narrow_shim
  import nrw_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int LSB_W  = $clog2(STRB_W),
  localparam int NSLOT  = 2 * STRB_W - 2
) (
  input  logic              up_awvalid,
  output logic              up_awready,
  input  logic [ADDR_W-1:0] up_awaddr,
  input  logic [2:0]        up_awsize,
  input  logic              up_wvalid,
  output logic              up_wready,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic [STRB_W-1:0] up_wstrb,
  input  logic              up_wlast,
  output logic              up_bvalid,
  input  logic              up_bready,
  output logic [1:0]        up_bresp,
  output logic              dn_awvalid,
  input  logic              dn_awready,
  output logic [ADDR_W-1:0] dn_awaddr,
  output logic [2:0]        dn_awsize,
  output logic              dn_wvalid,
  input  logic              dn_wready,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [STRB_W-1:0] dn_wstrb,
  output logic              dn_wlast,
  input  logic              dn_bvalid,
  output logic              dn_bready,
  input  logic [1:0]        dn_bresp
);
  logic [NSLOT-1:0] slot_hit;
  logic             narrow;
  logic [LSB_W-1:0] offset;
  axsize_t          nsize;

  nrw_strb_decode #(.STRB_W(STRB_W)) u_decode (
    .strb     (up_wstrb),
    .slot_hit (slot_hit),
    .narrow   (narrow),
    .offset   (offset),
    .nsize    (nsize)
  );

  nrw_aw_rewrite #(.ADDR_W(ADDR_W), .LSB_W(LSB_W)) u_rewrite (
    .addr_in  (up_awaddr),
    .size_in  (up_awsize),
    .narrow   (narrow),
    .offset   (offset),
    .nsize    (nsize),
    .addr_out (dn_awaddr),
    .size_out (dn_awsize)
  );

  nrw_chan_pass #(.DATA_W(DATA_W), .STRB_W(STRB_W)) u_pass (
    .up_awvalid (up_awvalid),
    .up_awready (up_awready),
    .dn_awvalid (dn_awvalid),
    .dn_awready (dn_awready),
    .up_wvalid  (up_wvalid),
    .up_wready  (up_wready),
    .up_wdata   (up_wdata),
    .up_wstrb   (up_wstrb),
    .up_wlast   (up_wlast),
    .dn_wvalid  (dn_wvalid),
    .dn_wready  (dn_wready),
    .dn_wdata   (dn_wdata),
    .dn_wstrb   (dn_wstrb),
    .dn_wlast   (dn_wlast),
    .up_bvalid  (up_bvalid),
    .up_bready  (up_bready),
    .up_bresp   (up_bresp),
    .dn_bvalid  (dn_bvalid),
    .dn_bready  (dn_bready),
    .dn_bresp   (dn_bresp)
  );
endmodule

// File: rtl/nrw_shim_chk.sv
module nrw_shim_chk #(
  parameter  int ADDR_W = 32,
  parameter  int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int LSB_W  = $clog2(STRB_W),
  localparam int NSLOT  = 2 * STRB_W - 2
) (
  input logic              up_awvalid,
  input logic              up_awready,
  input logic [ADDR_W-1:0] up_awaddr,
  input logic [2:0]        up_awsize,
  input logic              up_wvalid,
  input logic              up_wready,
  input logic [DATA_W-1:0] up_wdata,
  input logic [STRB_W-1:0] up_wstrb,
  input logic              up_wlast,
  input logic              up_bvalid,
  input logic              up_bready,
  input logic [1:0]        up_bresp,
  input logic              dn_awvalid,
  input logic              dn_awready,
  input logic [ADDR_W-1:0] dn_awaddr,
  input logic [2:0]        dn_awsize,
  input logic              dn_wvalid,
  input logic              dn_wready,
  input logic [DATA_W-1:0] dn_wdata,
  input logic [STRB_W-1:0] dn_wstrb,
  input logic              dn_wlast,
  input logic              dn_bvalid,
  input logic              dn_bready,
  input logic [1:0]        dn_bresp,
  input logic [NSLOT-1:0]  slot_hit
);
  logic changed;
  assign changed = (dn_awsize != up_awsize) ||
                   (dn_awaddr[LSB_W-1:0] != up_awaddr[LSB_W-1:0]);

  always_comb begin
    if (!$isunknown({up_awvalid, dn_awready})) begin
      p_aw_handshake_r6: assert final (dn_awvalid == up_awvalid && up_awready == dn_awready);
    end
    if (!$isunknown({up_wvalid, dn_wready})) begin
      p_w_handshake_r7: assert final (dn_wvalid == up_wvalid && up_wready == dn_wready);
    end
    if (!$isunknown({up_wdata, up_wstrb, up_wlast})) begin
      p_beat_forward_r8: assert final (dn_wdata == up_wdata && dn_wstrb == up_wstrb && dn_wlast == up_wlast);
    end
    if (!$isunknown({dn_bvalid, up_bready, dn_bresp})) begin
      p_resp_forward_r9: assert final (up_bvalid == dn_bvalid && dn_bready == up_bready && up_bresp == dn_bresp);
    end
    if (!$isunknown({up_awaddr, up_awsize, up_wstrb})) begin
      p_upper_bits_r5: assert final (dn_awaddr[ADDR_W-1:LSB_W] == up_awaddr[ADDR_W-1:LSB_W]);
      p_single_slot_r4: assert final ($onehot0(slot_hit));
      p_zero_strobe_r3: assert final (up_wstrb != '0 || (dn_awaddr == up_awaddr && dn_awsize == up_awsize));
      p_full_strobe_r4: assert final (up_wstrb != '1 || (dn_awaddr == up_awaddr && dn_awsize == up_awsize));
      p_run_matches_r2: assert final (!changed ||
        (int'(dn_awsize) < LSB_W && $countones(up_wstrb) == (1 << dn_awsize) &&
         up_wstrb[dn_awaddr[LSB_W-1:0]]));
    end
  end
endmodule

bind wstrb_narrow_shim nrw_shim_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .up_awvalid (up_awvalid),
  .up_awready (up_awready),
  .up_awaddr  (up_awaddr),
  .up_awsize  (up_awsize),
  .up_wvalid  (up_wvalid),
  .up_wready  (up_wready),
  .up_wdata   (up_wdata),
  .up_wstrb   (up_wstrb),
  .up_wlast   (up_wlast),
  .up_bvalid  (up_bvalid),
  .up_bready  (up_bready),
  .up_bresp   (up_bresp),
  .dn_awvalid (dn_awvalid),
  .dn_awready (dn_awready),
  .dn_awaddr  (dn_awaddr),
  .dn_awsize  (dn_awsize),
  .dn_wvalid  (dn_wvalid),
  .dn_wready  (dn_wready),
  .dn_wdata   (dn_wdata),
  .dn_wstrb   (dn_wstrb),
  .dn_wlast   (dn_wlast),
  .dn_bvalid  (dn_bvalid),
  .dn_bready  (dn_bready),
  .dn_bresp   (dn_bresp),
  .slot_hit   (slot_hit)
);

// File: tb/test_wstrb_narrow_shim.sv
module test_wstrb_narrow_shim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 1'b0;

  logic        up_awvalid, up_awready, up_wvalid, up_wready, up_wlast;
  logic [31:0] up_awaddr, up_wdata, dn_awaddr, dn_wdata;
  logic [2:0]  up_awsize, dn_awsize;
  logic [3:0]  up_wstrb, dn_wstrb;
  logic        up_bvalid, up_bready, dn_awvalid, dn_awready;
  logic        dn_wvalid, dn_wready, dn_wlast, dn_bvalid, dn_bready;
  logic [1:0]  up_bresp, dn_bresp;

  always #10 clk = ~clk;

  wstrb_narrow_shim i_wstrb_narrow_shim (
    .up_awvalid(up_awvalid), .up_awready(up_awready), .up_awaddr(up_awaddr),
    .up_awsize(up_awsize), .up_wvalid(up_wvalid), .up_wready(up_wready),
    .up_wdata(up_wdata), .up_wstrb(up_wstrb), .up_wlast(up_wlast),
    .up_bvalid(up_bvalid), .up_bready(up_bready), .up_bresp(up_bresp),
    .dn_awvalid(dn_awvalid), .dn_awready(dn_awready), .dn_awaddr(dn_awaddr),
    .dn_awsize(dn_awsize), .dn_wvalid(dn_wvalid), .dn_wready(dn_wready),
    .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb), .dn_wlast(dn_wlast),
    .dn_bvalid(dn_bvalid), .dn_bready(dn_bready), .dn_bresp(dn_bresp)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Expected address/size from the requirement text: narrow only for a
  // single byte, or two contiguous bytes starting at an even lane.
  function automatic void model(input logic [31:0] a, input logic [2:0] sz,
                                input logic [3:0] st, output logic [31:0] ea,
                                output logic [2:0] es, output int cls);
    int cnt = $countones(st);
    int lo = 0;
    logic [3:0] run;
    for (int i = 3; i >= 0; i--) if (st[i]) lo = i;
    run = 4'(((1 << cnt) - 1) << lo);
    ea = a;
    es = sz;
    cls = (st == 4'h0) ? 3 : 4;
    if (st != 4'h0 && (cnt == 1 || cnt == 2) && run == st && (lo % cnt) == 0) begin
      ea = {a[31:2], 2'(lo)};
      es = 3'(cnt - 1);
      cls = cnt;
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [4];
    logic [31:0] ea;
    logic [2:0]  es;
    int          cls;
    string       tag;
    addrs[0] = 32'h0000_5550; addrs[1] = 32'h0000_5553;
    addrs[2] = 32'hFFFF_FFFE; addrs[3] = 32'h1234_5679;

    up_awvalid = 0; up_awaddr = '0; up_awsize = '0; up_wvalid = 0;
    up_wdata = '0; up_wstrb = '0; up_wlast = 0; up_bready = 0;
    dn_awready = 0; dn_wready = 0; dn_bvalid = 0; dn_bresp = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7 / R6: idle after reset
    check(dn_wvalid == 0 && up_wready == 0, "R7 idle w", {dn_wvalid, up_wready}, 0);
    check(dn_awvalid == 0 && up_awready == 0, "R6 idle aw", {dn_awvalid, up_awready}, 0);

    // Exhaustive strobe sweep over several bases and sizes
    for (int ai = 0; ai < 4; ai++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int st = 0; st < 16; st++) begin
          @(negedge clk);
          up_awaddr = addrs[ai];
          up_awsize = 3'(sz);
          up_wstrb  = 4'(st);
          up_wdata  = addrs[ai] ^ {28'h0, 4'(st)} ^ 32'hA5C3_0F96;
          up_wlast  = st[0];
          #1;
          model(addrs[ai], 3'(sz), 4'(st), ea, es, cls);
          case (cls)
            1: tag = "R1 byte";
            2: tag = "R2 halfword";
            3: tag = "R3 zero strobe";
            default: tag = "R4 passthrough";
          endcase
          check(dn_awaddr[1:0] == ea[1:0] && dn_awsize == es, tag,
                {dn_awsize, dn_awaddr}, {es, ea});
          check(dn_awaddr[31:2] == addrs[ai][31:2], "R5 upper bits",
                dn_awaddr, addrs[ai]);
          check(dn_wdata == up_wdata && dn_wstrb == up_wstrb && dn_wlast == up_wlast,
                "R8 beat", {dn_wlast, dn_wstrb, dn_wdata}, {up_wlast, up_wstrb, up_wdata});
        end
      end
    end

    // Handshake sweep over all six valid/ready bits
    for (int v = 0; v < 64; v++) begin
      @(negedge clk);
      up_awvalid = v[0]; dn_awready = v[1];
      up_wvalid  = v[2]; dn_wready  = v[3];
      dn_bvalid  = v[4]; up_bready  = v[5];
      dn_bresp   = 2'(v[1:0] ^ v[5:4]);
      #1;
      check(dn_awvalid == v[0] && up_awready == v[1], "R6 aw handshake",
            {dn_awvalid, up_awready}, {v[0], v[1]});
      check(dn_wvalid == v[2] && up_wready == v[3], "R7 w handshake",
            {dn_wvalid, up_wready}, {v[2], v[3]});
      check(up_bvalid == v[4] && dn_bready == v[5] && up_bresp == 2'(v[1:0] ^ v[5:4]),
            "R9 response", {up_bvalid, dn_bready, up_bresp},
            {v[4], v[5], 2'(v[1:0] ^ v[5:4])});
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule